// File: doc/BRIEF.md
# Fractional Baud Divisor Decoder

This block takes the 24-bit baud setting that a control write delivers and turns it into a serial timing source. The setting's low 15 bits give a whole divisor. A 3-bit code, passed through a fixed scrambling table, gives a fraction in eighths. Together they form an 18-bit divisor counted in eighths. Three tiny settings (0, 1 and 2) skip this decoding and pick fixed fast rates instead.

The decoded divisor drives an accumulator-based tick generator. Every reference clock the accumulator gains a fixed step of 16. Each time it reaches the divisor, the divisor is taken off and a one-cycle tick goes out. Over time the tick rate is therefore 16/divisor of the reference clock.

For debug, the block also reports the nominal baud rate: the 48 MHz reference divided by the divisor, then halved with upward rounding. A new setting takes effect on the load strobe. The load also clears the accumulator, so the first tick after a change comes at a known time.

Top module: `baud_frac_divider`

## Requirements
- R1: After reset, before any load, the divisor is 8 and the nominal rate is 3000000. A tick is produced on every cycle.
- R2: A whole 24-bit setting of 0, 1 or 2 gives a divisor of 8, 12 or 16 respectively, and a nominal rate of 3000000, 2000000 or 1500000. These three settings skip the regular decoding.
- R3: For any other setting, divisor bits 17:3 equal setting bits 14:0. Setting bits 23:17 have no effect on the divisor.
- R4: The code in setting bits 16:14 places an eighths value in divisor bits 2:0. The mapping is: code 0→0, 1→4, 2→2, 3→1, 4→3, 5→5, 6→6, 7→7.
- R5: The nominal rate is computed as follows. Take q = floor(48000000 / divisor). The rate is q/2 when q is even and (q+1)/2 when q is odd.
- R6: Take a divisor D of 16 or more. Over the N cycles that follow the cycle after a load, exactly floor(16·N/D) ticks are produced.
- R7: For a nonzero divisor of 16 or less, a tick is produced on every cycle except the one right after a load.
- R8: The load clears the accumulator and forces the tick low in the following cycle. The divisor and rate change only on a load, and become visible one cycle after the strobe. As a result, with divisor 210 the first tick after a load appears on the 14th cycle.
- R9: A divisor of zero holds the tick low and gives a nominal rate of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_load | input | 1 | Strobe that captures `enc_value` |
| enc_value | input | 24 | Encoded baud setting |
| baud_tick | output | 1 | One-cycle rate tick |
| divisor | output | 18 | Decoded divisor in eighths |
| nominal_rate | output | 32 | Nominal baud rate for debug, in Hz |

## Verification
The assertions assume `enc_load` is a clean synchronous strobe. They also assume `enc_value` is only meaningful in the cycle the strobe is high. The stimulus meets this by driving both inputs on the falling clock edge and holding the strobe for exactly one cycle. The every-cycle tick property assumes no load occurs in between, so the bench spaces its loads and counts ticks only in load-free windows. Settings with a zero divisor are applied on purpose, to exercise the quiet-tick rule.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
  localparam int ENC_W    = 24;
  localparam int INT_W    = 15;
  localparam int CODE_LSB = 14;
  localparam int CODE_W   = 3;
  localparam int DIV_W    = INT_W + CODE_W;
  localparam int RATE_W   = 32;
  localparam int REF_HZ   = 48000000;
  localparam int STEP     = 16;

  typedef logic [ENC_W-1:0]  enc_t;
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [RATE_W-1:0] rate_t;

  // scrambled fraction code -> eighths
  function automatic logic [CODE_W-1:0] code_to_eighths(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 3'd0;
      3'd1:    return 3'd4;
      3'd2:    return 3'd2;
      3'd3:    return 3'd1;
      3'd4:    return 3'd3;
      3'd5:    return 3'd5;
      3'd6:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic div_t decode_div(input enc_t enc);
    if (enc == ENC_W'(0))      return DIV_W'(8);
    else if (enc == ENC_W'(1)) return DIV_W'(12);
    else if (enc == ENC_W'(2)) return DIV_W'(16);
    else return {enc[INT_W-1:0], {CODE_W{1'b0}}}
              | DIV_W'(code_to_eighths(enc[CODE_LSB +: CODE_W]));
  endfunction

  function automatic rate_t rate_of(input div_t d);
    rate_t q;
    if (d == '0) return '0;
    q = rate_t'(REF_HZ) / rate_t'(d);
    return (q >> 1) + rate_t'(q[0]);
  endfunction
endpackage

// File: rtl/baud_enc_decode.sv
module baud_enc_decode
  import baud_frac_pkg::*;
(
  input  enc_t  enc,
  output div_t  div,
  output rate_t rate
);
  div_t div_w;
  assign div_w = decode_div(enc);
  assign div   = div_w;
  assign rate  = rate_of(div_w);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 18,
  parameter int STEP  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W:0]   acc_o
);
  localparam int ACC_W = DIV_W + 1;

  logic [ACC_W-1:0] acc, sum, rem, acc_nxt, div_x;
  logic             hit;

  always_comb begin
    div_x = {1'b0, div};
    sum   = acc + ACC_W'(STEP);
    rem   = sum - div_x;
    hit   = (div != '0) && (sum >= div_x);
    if (div == '0)      acc_nxt = '0;
    else if (!hit)      acc_nxt = sum;
    else if (rem >= div_x) acc_nxt = '0;   // divisor below step: saturate
    else                acc_nxt = rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (clear) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_nxt;
      tick <= hit;
    end
  end

  assign acc_o = acc;
endmodule

// File: rtl/baud_frac_divider.sv
module baud_frac_divider
  import baud_frac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_load,
  input  logic [ENC_W-1:0]  enc_value,
  output logic              baud_tick,
  output logic [DIV_W-1:0]  divisor,
  output logic [RATE_W-1:0] nominal_rate
);
  localparam div_t  RST_DIV  = decode_div('0);
  localparam rate_t RST_RATE = rate_of(RST_DIV);

  div_t          dec_div;
  rate_t         dec_rate;
  div_t          div_q;
  rate_t         rate_q;
  logic [DIV_W:0] tick_acc;

  baud_enc_decode u_dec (
    .enc  (enc_value),
    .div  (dec_div),
    .rate (dec_rate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= RST_DIV;
      rate_q <= RST_RATE;
    end else if (enc_load) begin
      div_q  <= dec_div;
      rate_q <= dec_rate;
    end
  end

  baud_tick_gen #(.DIV_W(DIV_W), .STEP(STEP)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (enc_load),
    .div   (div_q),
    .tick  (baud_tick),
    .acc_o (tick_acc)
  );

  assign divisor      = div_q;
  assign nominal_rate = rate_q;
endmodule

// File: rtl/baud_frac_checker.sv
module baud_frac_checker
  import baud_frac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enc_load,
  input logic              baud_tick,
  input logic [DIV_W-1:0]  divisor,
  input logic [RATE_W-1:0] nominal_rate,
  input logic [DIV_W:0]    tick_acc
);
  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !baud_tick);

  p_zero_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (nominal_rate == '0));

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enc_load |=> (!baud_tick && tick_acc == '0));

  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_load |=> ($stable(divisor) && $stable(nominal_rate)));

  p_fast_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_load && divisor != '0 && divisor <= DIV_W'(STEP)) |=> baud_tick);

  p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |-> (tick_acc < {1'b0, divisor}));
endmodule

bind baud_frac_divider baud_frac_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enc_load     (enc_load),
  .baud_tick    (baud_tick),
  .divisor      (divisor),
  .nominal_rate (nominal_rate),
  .tick_acc     (tick_acc)
);

// File: tb/sim_baud_frac_divider.sv
module sim_baud_frac_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_load = 1'b0;
  logic [23:0] enc_value = '0;
  logic        baud_tick;
  logic [17:0] divisor;
  logic [31:0] nominal_rate;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  baud_frac_divider u0 (
    .clk(clk), .rst_n(rst_n), .enc_load(enc_load), .enc_value(enc_value),
    .baud_tick(baud_tick), .divisor(divisor), .nominal_rate(nominal_rate)
  );

  function automatic longint exp_frac(input int code);
    longint t[8] = '{0, 4, 2, 1, 3, 5, 6, 7};
    return t[code];
  endfunction

  function automatic longint exp_div(input longint enc);
    if (enc < 3) return 8 + 4 * enc;
    return ((enc % 32768) * 8) + exp_frac(int'((enc / 16384) % 8));
  endfunction

  function automatic longint exp_rate(input longint d);
    longint q;
    if (d == 0) return 0;
    q = 48000000 / d;
    return (q + 1) / 2;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [23:0] enc);
    @(negedge clk);
    enc_value = enc;
    enc_load  = 1'b1;
    @(negedge clk);
    enc_load  = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (baud_tick) c++;
    end
  endtask

  task automatic t_reset();
    int c;
    chk("R1", "reset divisor", divisor, 8);
    chk("R1", "reset rate", nominal_rate, 3000000);
    count_ticks(10, c);
    chk("R1", "reset ticks in 10", c, 10);
  endtask

  task automatic t_special();
    for (int e = 0; e < 3; e++) begin
      do_load(24'(e));
      chk("R2", "special divisor", divisor, 8 + 4 * e);
      chk("R2", "special rate", nominal_rate, 6000000 / (2 + e));
    end
  endtask

  task automatic t_integer();
    do_load(24'h000003);
    chk("R3", "int divisor enc 3", divisor, 24);
    do_load(24'hFE0003);
    chk("R3", "upper bits ignored", divisor, 24);
    do_load(24'h800001);
    chk("R3", "not special when upper set", divisor, 8);
    do_load(24'h007FFF);
    chk("R3", "max integer", divisor, exp_div(24'h007FFF));
  endtask

  task automatic t_frac();
    for (int code = 0; code < 8; code++) begin
      logic [23:0] e;
      e = 24'(code * 16384 + 5);
      do_load(e);
      chk("R4", $sformatf("frac code %0d", code), divisor, exp_div(longint'(e)));
    end
  endtask

  task automatic t_rate();
    logic [23:0] list[4] = '{24'h000003, 24'h00801A, 24'h010005, 24'h018004};
    for (int i = 0; i < 4; i++) begin
      do_load(list[i]);
      chk("R5", $sformatf("rate enc %h", list[i]), nominal_rate, exp_rate(exp_div(longint'(list[i]))));
    end
  endtask

  task automatic t_tick_count();
    logic [23:0] list[4] = '{24'h000003, 24'h00801A, 24'h010005, 24'h018004};
    int          lens[4] = '{30, 420, 86, 100};
    int c;
    for (int i = 0; i < 4; i++) begin
      longint d;
      d = exp_div(longint'(list[i]));
      do_load(list[i]);
      chk("R8", "tick low after load", baud_tick, 0);
      count_ticks(lens[i], c);
      chk("R6", $sformatf("tick count enc %h", list[i]), c, (16 * lens[i]) / d);
    end
  endtask

  task automatic t_fast();
    logic [23:0] list[3] = '{24'h000001, 24'h000002, 24'h800001};
    int c;
    for (int i = 0; i < 3; i++) begin
      do_load(list[i]);
      count_ticks(20, c);
      chk("R7", $sformatf("fast ticks enc %h", list[i]), c, 20);
    end
  endtask

  task automatic t_load_clear();
    int first;
    do_load(24'h00801A);
    repeat (50) @(negedge clk);
    do_load(24'h00801A);
    first = 0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (baud_tick && first == 0) first = k;
    end
    chk("R8", "first tick cycle after reload", first, 14);
    @(negedge clk);
    enc_value = 24'h000005;
    repeat (3) @(negedge clk);
    chk("R8", "divisor held without load", divisor, 210);
  endtask

  task automatic t_zero();
    int c;
    do_load(24'h020000);
    chk("R9", "zero divisor", divisor, 0);
    chk("R9", "zero rate", nominal_rate, 0);
    count_ticks(100, c);
    chk("R9", "ticks with zero divisor", c, 0);
    do_load(24'h000003);
    count_ticks(3, c);
    chk("R9", "recovery ticks", c, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_special();
    t_integer();
    t_frac();
    t_rate();
    t_tick_count();
    t_fast();
    t_load_clear();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule